// File: doc/BRIEF.md
# Single-Wire Bus Master Time-Slot Engine

This block drives one open-drain, single-wire serial bus as its master. On each host request it produces exactly one bus time slot: a reset pulse followed by a presence check, a write slot that sends a one or a zero, or a read slot that samples one bit sent back by a slave. Each request chooses between two speed grades: standard and overdrive. All slot widths and sample points are set per grade.

The host puts an operation code, a write bit and a speed flag on its inputs and pulses a start strobe. The engine holds `busy` until the slot, including its recovery gap, is complete. It then pulses `rsp_done` for one cycle and presents the sampled bit or the presence flag on `rsp_bit`. On the bus side, `bus_pull_low` enables an external open-drain driver. The wire is read back on `bus_line_in` through a synchronizer chain.

All slot timers count a one-microsecond tick taken from a prescaler of the system clock. Slot lengths are given in microseconds, independent of the clock rate. The read sample point is a fixed offset after the master ends its own low pulse.

Top module: `owm_slot_engine`

## Requirements
- R1: A write-zero slot (cmd_op 2'b01, cmd_wbit 0) holds `bus_pull_low` high for 65 us at standard speed (cmd_fast 0) and 8 us at overdrive speed (cmd_fast 1).
- R2: A write-one slot (cmd_op 2'b01, cmd_wbit 1) holds `bus_pull_low` high for 6 us at standard speed and 1 us at overdrive speed. After any write slot, `rsp_bit` is 0 at `rsp_done`.
- R3: A read slot (cmd_op 2'b10) pulls low for 6 us (standard) or 1 us (overdrive). It then samples the line 8 us (standard) or 1 us (overdrive) after releasing it. `rsp_bit` equals the sampled line level.
- R4: A reset slot (cmd_op 2'b00) pulls low for 480 us (standard) or 48 us (overdrive). It samples the line 70 us or 8 us after release and ends 480 us or 48 us after release. `rsp_bit` is 1 when the sampled line was low (a device is present) and 0 otherwise.
- R5: Every write and read slot ends with the line released for at least 5 us (standard) or 2 us (overdrive). Such a slot lasts at least 70 us or 10 us in total, and `busy` stays high for exactly that total.
- R6: `busy` rises only on the clock edge that accepts a start strobe, and stays high until the slot ends. `rsp_done` is a single-cycle pulse, raised in the cycle where `busy` has fallen.
- R7: A start strobe that arrives while `busy` is high is ignored. The running slot keeps its length and produces exactly one `rsp_done`.
- R8: A start strobe with cmd_op 2'b11 is ignored. No slot starts, `busy` stays low and no `rsp_done` is produced.
- R9: After synchronous reset (rst_n low), `busy`, `rsp_done`, `rsp_bit` and `bus_pull_low` are all 0.
- R10: Every slot time is an exact multiple of CLK_PER_US system clock cycles, counted from the edge that accepts the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | One-cycle request strobe |
| cmd_op | input | 2 | 00 reset/presence, 01 write, 10 read, 11 reserved |
| cmd_wbit | input | 1 | Bit value for a write slot |
| cmd_fast | input | 1 | 1 selects overdrive timing, 0 standard |
| rsp_bit | output | 1 | Read bit or presence flag, valid at rsp_done |
| rsp_done | output | 1 | One-cycle pulse when a slot completes |
| busy | output | 1 | High while a slot is in progress |
| bus_pull_low | output | 1 | Active-high enable for the external open-drain pull-down |
| bus_line_in | input | 1 | Raw bus level, synchronized internally |

## Verification
The embedded properties cover the following on every cycle:
- `busy` rises only in response to a strobe.
- The slot timer never steps backwards or passes the slot end, so a second strobe cannot restart a slot.
- `rsp_done` is a lone pulse with `busy` low.
- The pull-down is never active outside a slot, and the line is released at the sample point and before a slot ends.
- The prescaler tick is never back to back.

Only the directed scenarios can show the following:
- The exact low widths and slot lengths in clock cycles for each operation and speed.
- That the sample lands at the right moment: a slave pulling low after the sample point must read as 1.
- Presence detection with and without a responding device.
- That reserved codes and strobes during a slot leave the outputs untouched.

// File: rtl/owm_pkg.sv
// Package: shared request encoding for the single-wire slot engine.
// Assumes: operation code values are fixed by the host interface (R8 relies on 2'b11).
package owm_pkg;

    typedef enum logic [1:0] {
        OP_RESET = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_NONE  = 2'b11
    } owm_op_e;

    typedef struct packed {
        owm_op_e op;
        logic    wbit;
        logic    fast;
    } owm_req_t;

endpackage

// File: rtl/owm_tick_gen.sv
// Module: microsecond tick prescaler.
// Counts DIV system clocks per tick while run is high; restart realigns the
// count so the first tick arrives exactly DIV cycles after a slot starts.
// Assumes: DIV >= 1.
module owm_tick_gen #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pre_q;

    assign tick = run && !restart && (pre_q == LAST);

    // Advance the prescaler while a slot runs, wrap on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pre_q <= '0;
        end else if (run) begin
            pre_q <= (pre_q == LAST) ? '0 : pre_q + PW'(1);
        end
    end

    generate
        if (DIV > 1) begin : g_spacing_chk
            // R10: ticks are spaced by the divider, never back to back
            a_r10_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/owm_line_sync.sv
// Module: metastability synchronizer for the raw bus level.
// A chain of STAGES flops, reset to the idle (released, high) level.
// Assumes: STAGES >= 2.
module owm_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_raw,
    output logic line_s
);
    logic [STAGES-1:0] stg_q;

    generate
        for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
            // Shift the bus level one flop further down the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg_q[gi] <= 1'b1;
                end else if (gi == 0) begin
                    stg_q[gi] <= line_raw;
                end else begin
                    stg_q[gi] <= stg_q[(gi == 0) ? 0 : gi - 1];
                end
            end
        end
    endgenerate

    assign line_s = stg_q[STAGES-1];

endmodule

// File: rtl/owm_slot_timing.sv
// Module: per-slot timing table.
// Maps the captured request to low width, sample point and slot end, all
// in microseconds from slot start. Purely combinational.
// Assumes: parameter values keep the sample point after the low pulse and
// before the slot end.
module owm_slot_timing
    import owm_pkg::*;
#(
    parameter int UW        = 11,
    parameter int W0_STD    = 65,
    parameter int W0_OD     = 8,
    parameter int W1_STD    = 6,
    parameter int W1_OD     = 1,
    parameter int RDL_STD   = 6,
    parameter int RDL_OD    = 1,
    parameter int RDS_STD   = 8,
    parameter int RDS_OD    = 1,
    parameter int RST_STD   = 480,
    parameter int RST_OD    = 48,
    parameter int PRS_STD   = 70,
    parameter int PRS_OD    = 8,
    parameter int REC_STD   = 5,
    parameter int REC_OD    = 2,
    parameter int SLOT_STD  = 70,
    parameter int SLOT_OD   = 10
) (
    input  owm_req_t        req,
    output logic [UW-1:0]   low_us,
    output logic [UW-1:0]   samp_us,
    output logic [UW-1:0]   stop_us,
    output logic            samp_en
);
    logic [UW-1:0] rec_us;
    logic [UW-1:0] slot_us;
    logic [UW-1:0] min_stop;

    // Select the low width and sample point for the requested operation.
    always_comb begin
        rec_us  = req.fast ? UW'(REC_OD)  : UW'(REC_STD);
        slot_us = req.fast ? UW'(SLOT_OD) : UW'(SLOT_STD);
        samp_en = 1'b0;
        case (req.op)
            OP_RESET: begin
                low_us  = req.fast ? UW'(RST_OD) : UW'(RST_STD);
                samp_us = low_us + (req.fast ? UW'(PRS_OD) : UW'(PRS_STD));
                samp_en = 1'b1;
            end
            OP_READ: begin
                low_us  = req.fast ? UW'(RDL_OD) : UW'(RDL_STD);
                samp_us = low_us + (req.fast ? UW'(RDS_OD) : UW'(RDS_STD));
                samp_en = 1'b1;
            end
            OP_WRITE: begin
                if (req.wbit) low_us = req.fast ? UW'(W1_OD) : UW'(W1_STD);
                else          low_us = req.fast ? UW'(W0_OD) : UW'(W0_STD);
                samp_us = low_us;
            end
            default: begin
                low_us  = UW'(1);
                samp_us = low_us;
            end
        endcase
    end

    // Slot end: reset doubles its low time, others take the longer of the
    // minimum slot and low-plus-recovery.
    always_comb begin
        min_stop = low_us + rec_us;
        if (req.op == OP_RESET) stop_us = low_us + low_us;
        else                    stop_us = (min_stop > slot_us) ? min_stop : slot_us;
    end

    // R5: the slot always ends after the low pulse; sample lies inside the slot
    always_comb begin
        a_r5_stop_after_low: assert (stop_us > low_us);
        a_r3_samp_in_slot: assert (!samp_en || (samp_us > low_us && samp_us < stop_us));
    end

endmodule

// File: rtl/owm_slot_ctrl.sv
// Module: slot sequencer.
// Accepts a request when idle, drives the pull-down for the low width,
// samples the synchronized line at the sample point and ends the slot with
// a one-cycle done pulse. Counts microseconds from the tick input.
// Assumes: timing inputs are derived from req_q and stable during a slot.
module owm_slot_ctrl
    import owm_pkg::*;
#(
    parameter int UW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  owm_req_t      req_in,
    input  logic          tick,
    input  logic          line_s,
    input  logic [UW-1:0] low_us,
    input  logic [UW-1:0] samp_us,
    input  logic [UW-1:0] stop_us,
    input  logic          samp_en,
    output owm_req_t      req_q,
    output logic          accept,
    output logic          busy,
    output logic          pull_low,
    output logic          done,
    output logic          rsp_bit
);
    logic [UW-1:0] us_cnt;
    logic [UW-1:0] us_nxt;
    logic          at_end;
    logic          at_samp;

    assign accept  = start && !busy && (req_in.op != OP_NONE);
    assign us_nxt  = us_cnt + UW'(1);
    assign at_end  = busy && tick && (us_nxt == stop_us);
    assign at_samp = busy && tick && samp_en && (us_nxt == samp_us);

    // Slot state: capture request, count microseconds, end the slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= '{op: OP_NONE, wbit: 1'b0, fast: 1'b0};
            busy   <= 1'b0;
            us_cnt <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                req_q  <= req_in;
                busy   <= 1'b1;
                us_cnt <= '0;
            end else if (busy && tick) begin
                us_cnt <= at_end ? '0 : us_nxt;
                if (at_end) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // Pull-down enable: high from acceptance until the low width elapses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pull_low <= 1'b0;
        end else if (accept) begin
            pull_low <= 1'b1;
        end else if (busy && tick) begin
            pull_low <= !at_end && (us_nxt < low_us);
        end
    end

    // Response bit: cleared at acceptance, loaded at the sample point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_bit <= 1'b0;
        end else if (accept) begin
            rsp_bit <= 1'b0;
        end else if (at_samp) begin
            rsp_bit <= (req_q.op == OP_RESET) ? !line_s : line_s;
        end
    end

    // R6: busy rises only on an accepted strobe
    a_r6_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    // R6: done is a lone pulse with busy already low
    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7: a running slot is never restarted by a new strobe
    a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (us_cnt >= $past(us_cnt)));
    // R5: the timer stays inside the slot
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (us_cnt < stop_us));
    // R2: no pull-down outside a slot
    a_r2_pull_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
        pull_low |-> busy);
    // R3: line already released at the sample point
    a_r3_sample_released: assert property (@(posedge clk) disable iff (!rst_n)
        at_samp |-> !pull_low);
    // R5: slot ends with the line released
    a_r5_release_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        at_end |-> !pull_low);

endmodule

// File: rtl/owm_slot_engine.sv
// Module: single-wire bus master time-slot engine (top).
// Generates reset/presence, write and read slots at two speeds from a host
// strobe, and returns the sampled bit with a done pulse.
// Assumes: CLK_PER_US system clocks make one microsecond; the pull-down
// output drives an external open-drain pad, bus_line_in is asynchronous.
module owm_slot_engine
    import owm_pkg::*;
#(
    parameter int CLK_PER_US  = 100,
    parameter int SYNC_STAGES = 2,
    parameter int W0_STD      = 65,
    parameter int W0_OD       = 8,
    parameter int W1_STD      = 6,
    parameter int W1_OD       = 1,
    parameter int RDL_STD     = 6,
    parameter int RDL_OD      = 1,
    parameter int RDS_STD     = 8,
    parameter int RDS_OD      = 1,
    parameter int RST_STD     = 480,
    parameter int RST_OD      = 48,
    parameter int PRS_STD     = 70,
    parameter int PRS_OD      = 8,
    parameter int REC_STD     = 5,
    parameter int REC_OD      = 2,
    parameter int SLOT_STD    = 70,
    parameter int SLOT_OD     = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_start,
    input  logic [1:0] cmd_op,
    input  logic       cmd_wbit,
    input  logic       cmd_fast,
    output logic       rsp_bit,
    output logic       rsp_done,
    output logic       busy,
    output logic       bus_pull_low,
    input  logic       bus_line_in
);
    localparam int T_MAX = 2 * RST_STD + SLOT_STD + W0_STD;
    localparam int UW    = $clog2(T_MAX + 1);

    owm_req_t      req_in;
    owm_req_t      req_q;
    logic          accept;
    logic          tick;
    logic          line_s;
    logic [UW-1:0] low_us;
    logic [UW-1:0] samp_us;
    logic [UW-1:0] stop_us;
    logic          samp_en;

    assign req_in = '{op: owm_op_e'(cmd_op), wbit: cmd_wbit, fast: cmd_fast};

    owm_tick_gen #(.DIV(CLK_PER_US)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (accept),
        .run     (busy),
        .tick    (tick)
    );

    owm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_raw (bus_line_in),
        .line_s   (line_s)
    );

    owm_slot_timing #(
        .UW(UW),
        .W0_STD(W0_STD), .W0_OD(W0_OD), .W1_STD(W1_STD), .W1_OD(W1_OD),
        .RDL_STD(RDL_STD), .RDL_OD(RDL_OD), .RDS_STD(RDS_STD), .RDS_OD(RDS_OD),
        .RST_STD(RST_STD), .RST_OD(RST_OD), .PRS_STD(PRS_STD), .PRS_OD(PRS_OD),
        .REC_STD(REC_STD), .REC_OD(REC_OD), .SLOT_STD(SLOT_STD), .SLOT_OD(SLOT_OD)
    ) u_timing (
        .req     (req_q),
        .low_us  (low_us),
        .samp_us (samp_us),
        .stop_us (stop_us),
        .samp_en (samp_en)
    );

    owm_slot_ctrl #(.UW(UW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cmd_start),
        .req_in   (req_in),
        .tick     (tick),
        .line_s   (line_s),
        .low_us   (low_us),
        .samp_us  (samp_us),
        .stop_us  (stop_us),
        .samp_en  (samp_en),
        .req_q    (req_q),
        .accept   (accept),
        .busy     (busy),
        .pull_low (bus_pull_low),
        .done     (rsp_done),
        .rsp_bit  (rsp_bit)
    );

endmodule

// File: tb/tb_owm_slot_engine.sv
// Directed bench for the slot engine with a simple slave model on the wire.
module tb_owm_slot_engine;
    localparam int DIV = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_start = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic cmd_wbit = 1'b0;
    logic cmd_fast = 1'b0;
    logic rsp_bit, rsp_done, busy, bus_pull_low;
    logic slave_low = 1'b0;
    logic bus_line;

    int total = 0;
    int bad = 0;
    int m_low, m_busy, m_done;
    logic m_rb;

    always #5 clk = ~clk;
    assign bus_line = !(bus_pull_low || slave_low);

    owm_slot_engine #(.CLK_PER_US(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
        .cmd_wbit(cmd_wbit), .cmd_fast(cmd_fast), .rsp_bit(rsp_bit),
        .rsp_done(rsp_done), .busy(busy), .bus_pull_low(bus_pull_low),
        .bus_line_in(bus_line)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Run one slot; slave holds the line low for [wlo,whi) us; inj = cycle
    // index at which a second strobe is injected (-1 for none).
    task automatic run_slot(input logic [1:0] op, input logic wb, input logic fs,
                            input int wlo, input int whi, input int inj);
        int k = 0;
        int tail = 0;
        bit seen = 0;
        m_low = 0; m_busy = 0; m_done = 0; m_rb = 1'b0;
        @(negedge clk);
        cmd_op = op; cmd_wbit = wb; cmd_fast = fs; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        while (tail < 3 * DIV + 4 && k < 20000) begin
            if (bus_pull_low) m_low++;
            if (busy) m_busy++;
            if (rsp_done) begin m_done++; m_rb = rsp_bit; seen = 1; end
            if (seen) tail++;
            slave_low = (k >= wlo * DIV) && (k < whi * DIV);
            cmd_start = (k == inj);
            if (k == inj) cmd_op = 2'b00;
            @(negedge clk);
            k++;
        end
        slave_low = 1'b0;
        cmd_start = 1'b0;
    endtask

    task automatic t_reset_state;
        @(negedge clk);
        chk(!busy && !rsp_done && !rsp_bit && !bus_pull_low, "R9 outputs after reset",
            {busy, rsp_done, rsp_bit, bus_pull_low}, 0);
    endtask

    task automatic t_write(input logic fs, input logic wb, input int low_us, input int stop_us, input int rec_us);
        run_slot(2'b01, wb, fs, 0, 0, -1);
        if (wb) chk(m_low == low_us * DIV, "R2 write-one low width", m_low, low_us * DIV);
        else    chk(m_low == low_us * DIV, "R1 write-zero low width (R10 scaled)", m_low, low_us * DIV);
        chk(m_busy == stop_us * DIV, "R5 slot length", m_busy, stop_us * DIV);
        chk(m_busy - m_low >= rec_us * DIV, "R5 recovery gap", m_busy - m_low, rec_us * DIV);
        chk(m_done == 1, "R6 single done", m_done, 1);
        chk(m_rb == 1'b0, "R2 write response bit", int'(m_rb), 0);
    endtask

    task automatic t_read(input logic fs, input int wlo, input int whi, input logic exp_bit,
                          input int low_us, input int stop_us);
        run_slot(2'b10, 1'b0, fs, wlo, whi, -1);
        chk(m_low == low_us * DIV, "R3 read low width", m_low, low_us * DIV);
        chk(m_busy == stop_us * DIV, "R5 read slot length", m_busy, stop_us * DIV);
        chk(m_rb == exp_bit, "R3 read sampled bit", int'(m_rb), int'(exp_bit));
    endtask

    task automatic t_presence(input logic fs, input int wlo, input int whi, input logic exp_bit,
                              input int low_us);
        run_slot(2'b00, 1'b0, fs, wlo, whi, -1);
        chk(m_low == low_us * DIV, "R4 reset low width", m_low, low_us * DIV);
        chk(m_busy == 2 * low_us * DIV, "R4 reset slot length", m_busy, 2 * low_us * DIV);
        chk(m_rb == exp_bit, "R4 presence flag", int'(m_rb), int'(exp_bit));
        chk(m_done == 1, "R6 reset done", m_done, 1);
    endtask

    task automatic t_restart_ignored;
        run_slot(2'b01, 1'b0, 1'b0, 0, 0, 100);
        chk(m_low == 65 * DIV, "R7 low width unchanged", m_low, 65 * DIV);
        chk(m_busy == 70 * DIV, "R7 slot length unchanged", m_busy, 70 * DIV);
        chk(m_done == 1, "R7 one done only", m_done, 1);
    endtask

    task automatic t_reserved;
        int hits = 0;
        @(negedge clk);
        cmd_op = 2'b11; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        for (int i = 0; i < 6 * DIV; i++) begin
            if (busy || rsp_done || bus_pull_low) hits++;
            @(negedge clk);
        end
        chk(hits == 0, "R8 reserved code ignored", hits, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_write(1'b0, 1'b0, 65, 70, 5);
        t_write(1'b1, 1'b0, 8, 10, 2);
        t_write(1'b0, 1'b1, 6, 70, 5);
        t_write(1'b1, 1'b1, 1, 10, 2);
        t_read(1'b0, 0, 70, 1'b0, 6, 70);
        t_read(1'b0, 0, 0, 1'b1, 6, 70);
        t_read(1'b0, 16, 40, 1'b1, 6, 70);
        t_read(1'b1, 0, 10, 1'b0, 1, 10);
        t_read(1'b1, 4, 9, 1'b1, 1, 10);
        t_presence(1'b0, 495, 600, 1'b1, 480);
        t_write(1'b0, 1'b1, 6, 70, 5);
        t_presence(1'b0, 0, 0, 1'b0, 480);
        t_presence(1'b1, 52, 70, 1'b1, 48);
        t_presence(1'b1, 0, 0, 1'b0, 48);
        t_restart_ignored();
        t_reserved();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule